// File: doc/BRIEF.md
# E3 Receive Error Monitor

This block gathers the error events that an E3 receive framer reports once per frame and presents them to a byte-wide processor bus. Two 16-bit counters are kept. One adds up the EM-byte parity errors, and the framer gives their number for each frame. The other counts received frames that carry the far-end-block-error flag. Both counters stop at their maximum value, and a read clears them. A status byte keeps one flag for each event type. A read clears the flags, and an enable byte selects which flags drive a single active-high interrupt line.

A counter is read high byte first. The high-byte read returns the upper byte. In the same cycle it copies the lower byte into a holding register and clears the whole counter. A later low-byte read returns the held byte, so the two bytes belong to the same value. For every frame that arrives with an EM-byte error, the block sends a one-cycle request to the local transmit framer. That request sets the error flag in the next outgoing frame, so the far end learns about the error.

Top module: `e3_err_monitor`

## Requirements
- R1: `ev_bip_bits` gives the number of EM-byte parity errors (0 to 8) in a frame. The parity counter adds that number. Its high byte reads at 0x54 and its low byte at 0x55.
- R2: Each cycle with `ev_febe` high adds one to the far-end error counter. Its high byte reads at 0x56 and its low byte at 0x57.
- R3: A high-byte read returns count[15:8], copies count[7:0] into a holding byte and clears the counter. A low-byte read returns the holding byte and changes nothing.
- R4: A counter stops at 0xFFFF and never wraps.
- R5: An increment in the same cycle as a high-byte read leaves the counter at that increment's amount, so no event is lost.
- R6: The status byte reads at 0x15. Bit 6 is trail-trace change, bit 4 is far-end error, bit 3 is remote failure (FERF), bit 2 is parity error (nonzero `ev_bip_bits`), bit 1 is framing-byte error and bit 0 is payload mismatch. Bits 7 and 5 always read 0.
- R7: A status bit sets on its event and clears when the status byte is read. A bit whose event arrives in the same cycle as the read stays set.
- R8: The enable byte at 0x14 is written and read with the same bit layout as the status byte. Bits 7 and 5 read 0. `irq` is high exactly when some enabled status bit is set.
- R9: `tx_febe_req` is high for exactly the one cycle after each cycle in which `ev_bip_bits` is nonzero.
- R10: After reset, both counters, both holding bytes, the status byte, the enable byte, `irq` and `tx_febe_req` are all 0. Unmapped addresses read 0, and `bus_rdata` is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_bip_bits | input | 4 | EM-byte parity errors in this frame, 0 when none |
| ev_febe | input | 1 | Received frame has its far-end error flag set |
| ev_ferf | input | 1 | Received frame has remote failure set |
| ev_fas_err | input | 1 | Framing byte error |
| ev_trail_chg | input | 1 | Trail-trace message changed |
| ev_pld_mis | input | 1 | Payload type mismatch |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Interrupt, active high |
| tx_febe_req | output | 1 | One-cycle request to flag far-end error on the next transmitted frame |

## Verification
The assertions assume that each event input is a single-cycle strobe, with at most one strobe per frame. They also assume that `ev_bip_bits` never exceeds 8, so a clearing read always leaves a counter well below its maximum. The bench drives each event for exactly one cycle and keeps the parity count within 0 to 8. It makes every read a one-cycle strobe. It places events deliberately in the same cycle as a clearing read so that the rules on coincident events are exercised.

// File: rtl/e3mon_pkg.sv
package e3mon_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned ERR_W  = 4;

  localparam logic [BYTE_W-1:0] A_IRQ_EN   = 8'h14;
  localparam logic [BYTE_W-1:0] A_IRQ_STAT = 8'h15;
  localparam logic [BYTE_W-1:0] A_BIP_HI   = 8'h54;
  localparam logic [BYTE_W-1:0] A_BIP_LO   = 8'h55;
  localparam logic [BYTE_W-1:0] A_FEBE_HI  = 8'h56;
  localparam logic [BYTE_W-1:0] A_FEBE_LO  = 8'h57;

  // status bit positions, decoded by software
  localparam int unsigned SB_PLD  = 0;
  localparam int unsigned SB_FAS  = 1;
  localparam int unsigned SB_BIP  = 2;
  localparam int unsigned SB_FERF = 3;
  localparam int unsigned SB_FEBE = 4;
  localparam int unsigned SB_TTB  = 6;

  localparam logic [BYTE_W-1:0] STAT_LIVE = 8'h5F;
endpackage

// File: rtl/e3mon_sat_counter.sv
module e3mon_sat_counter #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned INC_W  = 4,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  inc,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_hold
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base_w;
  logic [CNT_W-1:0] cnt_d;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W + 1 - INC_W){1'b0}}, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  assign base_w  = rd_hi ? '0 : cnt_q;
  assign cnt_d   = sat_add(base_w, inc);
  assign hi_byte = cnt_q[CNT_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lo_hold <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (rd_hi) lo_hold <= cnt_q[BYTE_W-1:0];
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hi && cnt_q == {CNT_W{1'b1}}) |=> cnt_q == {CNT_W{1'b1}}); // R4
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |=> cnt_q >= $past(cnt_q)); // R4
  AST_CLR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> cnt_q == CNT_W'($past(inc))); // R5
  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> lo_hold == $past(cnt_q[BYTE_W-1:0])); // R3
endmodule

// File: rtl/e3mon_irq_status.sv
module e3mon_irq_status #(
  parameter int unsigned        W    = 8,
  parameter logic [W-1:0]       LIVE = 8'h5F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         rd_clr,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] en,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stat[i] <= 1'b0;
          en[i]   <= 1'b0;
        end else begin
          stat[i] <= (stat[i] & ~rd_clr) | set[i];
          if (en_wr) en[i] <= en_wdata[i];
        end
      end
    end else begin : g_dead
      assign stat[i] = 1'b0;
      assign en[i]   = 1'b0;
    end
  end

  assign irq = |(stat & en);

  AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set & LIVE)) |=> ((stat & $past(set & LIVE)) == $past(set & LIVE))); // R7
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set == '0) |=> stat == '0); // R7
endmodule

// File: rtl/e3_err_monitor.sv
module e3_err_monitor
  import e3mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ERR_W-1:0]  ev_bip_bits,
  input  logic              ev_febe,
  input  logic              ev_ferf,
  input  logic              ev_fas_err,
  input  logic              ev_trail_chg,
  input  logic              ev_pld_mis,
  input  logic [BYTE_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tx_febe_req
);
  logic              bip_hit_w;
  logic              rd_stat_w, rd_bip_hi_w, rd_febe_hi_w, wr_en_w;
  logic [BYTE_W-1:0] set_w, stat_w, en_w;
  logic [BYTE_W-1:0] bip_hi_w, bip_lo_w, febe_hi_w, febe_lo_w;
  logic              irq_w;

  assign bip_hit_w    = (ev_bip_bits != '0);
  assign rd_stat_w    = bus_rd && (bus_addr == A_IRQ_STAT);
  assign rd_bip_hi_w  = bus_rd && (bus_addr == A_BIP_HI);
  assign rd_febe_hi_w = bus_rd && (bus_addr == A_FEBE_HI);
  assign wr_en_w      = bus_wr && (bus_addr == A_IRQ_EN);

  always_comb begin
    set_w          = '0;
    set_w[SB_PLD]  = ev_pld_mis;
    set_w[SB_FAS]  = ev_fas_err;
    set_w[SB_BIP]  = bip_hit_w;
    set_w[SB_FERF] = ev_ferf;
    set_w[SB_FEBE] = ev_febe;
    set_w[SB_TTB]  = ev_trail_chg;
  end

  e3mon_sat_counter #(.BYTE_W(BYTE_W), .INC_W(ERR_W)) u_bip_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_bip_bits), .rd_hi(rd_bip_hi_w),
    .hi_byte(bip_hi_w), .lo_hold(bip_lo_w)
  );

  e3mon_sat_counter #(.BYTE_W(BYTE_W), .INC_W(1)) u_febe_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_febe), .rd_hi(rd_febe_hi_w),
    .hi_byte(febe_hi_w), .lo_hold(febe_lo_w)
  );

  e3mon_irq_status #(.W(BYTE_W), .LIVE(STAT_LIVE)) u_status (
    .clk(clk), .rst_n(rst_n), .set(set_w), .rd_clr(rd_stat_w),
    .en_wr(wr_en_w), .en_wdata(bus_wdata),
    .stat(stat_w), .en(en_w), .irq(irq_w)
  );

  assign irq = irq_w;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_IRQ_EN:   bus_rdata = en_w;
        A_IRQ_STAT: bus_rdata = stat_w;
        A_BIP_HI:   bus_rdata = bip_hi_w;
        A_BIP_LO:   bus_rdata = bip_lo_w;
        A_FEBE_HI:  bus_rdata = febe_hi_w;
        A_FEBE_LO:  bus_rdata = febe_lo_w;
        default:    bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_febe_req <= 1'b0;
    else        tx_febe_req <= bip_hit_w;
  end

  AST_FEBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_febe_req |-> $past(ev_bip_bits) != '0); // R9
  AST_FEBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bip_hit_w |=> tx_febe_req); // R9
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_w && set_w == '0) |=> !irq); // R8
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0); // R10
endmodule

// File: tb/test_e3_err_monitor.sv
`timescale 1ns/1ps
module test_e3_err_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ev_bip_bits = '0;
  logic       ev_febe = 0, ev_ferf = 0, ev_fas_err = 0, ev_trail_chg = 0, ev_pld_mis = 0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_rdata;
  logic       irq, tx_febe_req;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] s_rd;
  logic       s_irq, s_req;

  always #2.5 clk = ~clk;

  e3_err_monitor i_e3_err_monitor (
    .clk(clk), .rst_n(rst_n), .ev_bip_bits(ev_bip_bits), .ev_febe(ev_febe),
    .ev_ferf(ev_ferf), .ev_fas_err(ev_fas_err), .ev_trail_chg(ev_trail_chg),
    .ev_pld_mis(ev_pld_mis), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_febe_req(tx_febe_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // evs: [0] febe, [1] ferf, [2] fas, [3] trail, [4] payload
  task automatic step(input logic [3:0] bip, input logic [4:0] evs, input logic rd,
                      input logic wr, input logic [7:0] a, input logic [7:0] wd);
    @(negedge clk);
    ev_bip_bits = bip; ev_febe = evs[0]; ev_ferf = evs[1]; ev_fas_err = evs[2];
    ev_trail_chg = evs[3]; ev_pld_mis = evs[4];
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #1;
    s_rd = bus_rdata; s_irq = irq; s_req = tx_febe_req;
  endtask

  task automatic idle();         step(4'd0, 5'd0, 1'b0, 1'b0, 8'h00, 8'h00); endtask
  task automatic rd(input logic [7:0] a); step(4'd0, 5'd0, 1'b1, 1'b0, a, 8'h00); endtask

  task automatic t_reset();
    idle();
    chk("R10 irq", {15'd0, s_irq}, 16'd0);
    chk("R10 febe_req", {15'd0, s_req}, 16'd0);
    chk("R10 rdata idle", {8'd0, s_rd}, 16'd0);
    rd(8'h15); chk("R10 status", {8'd0, s_rd}, 16'd0);
    rd(8'h14); chk("R10 enable", {8'd0, s_rd}, 16'd0);
    rd(8'h54); chk("R10 bip hi", {8'd0, s_rd}, 16'd0);
    rd(8'h55); chk("R10 bip lo", {8'd0, s_rd}, 16'd0);
    rd(8'h56); chk("R10 febe hi", {8'd0, s_rd}, 16'd0);
    rd(8'h57); chk("R10 febe lo", {8'd0, s_rd}, 16'd0);
    rd(8'h33); chk("R10 unmapped", {8'd0, s_rd}, 16'd0);
  endtask

  task automatic t_bip_count();
    step(4'd3, 5'd0, 0, 0, 0, 0); step(4'd8, 5'd0, 0, 0, 0, 0); idle();
    step(4'd1, 5'd0, 0, 0, 0, 0);
    rd(8'h54); chk("R1 bip hi", {8'd0, s_rd}, 16'd0);
    rd(8'h55); chk("R1 bip lo sum 3+8+1", {8'd0, s_rd}, 16'd12);
    rd(8'h54); rd(8'h55); chk("R3 bip cleared by hi read", {8'd0, s_rd}, 16'd0);
  endtask

  task automatic t_febe_count();
    for (int i = 0; i < 5; i++) begin step(0, 5'b00001, 0, 0, 0, 0); idle(); end
    rd(8'h56); chk("R2 febe hi", {8'd0, s_rd}, 16'd0);
    rd(8'h57); chk("R2 febe lo", {8'd0, s_rd}, 16'd5);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 300; i++) step(0, 5'b00001, 0, 0, 0, 0);
    rd(8'h56); chk("R3 febe hi of 300", {8'd0, s_rd}, 16'd1);
    for (int i = 0; i < 10; i++) step(0, 5'b00001, 0, 0, 0, 0);
    rd(8'h57); chk("R3 held low byte of 300", {8'd0, s_rd}, 16'h2C);
    rd(8'h56); chk("R3 febe hi after clear", {8'd0, s_rd}, 16'd0);
    rd(8'h57); chk("R3 febe lo new events", {8'd0, s_rd}, 16'd10);
  endtask

  task automatic t_saturate();
    int total = 0;
    for (int i = 0; i < 8200; i++) begin step(4'd8, 5'd0, 0, 0, 0, 0); total += 8; end
    if (total > 65535) total = 65535;
    rd(8'h54); chk("R4 bip hi saturated", {8'd0, s_rd}, 16'(total >> 8));
    rd(8'h55); chk("R4 bip lo saturated", {8'd0, s_rd}, 16'(total & 255));
  endtask

  task automatic t_coincident();
    rd(8'h54); rd(8'h56);
    step(4'd5, 5'd0, 1, 0, 8'h54, 0);
    chk("R5 bip hi read during event", {8'd0, s_rd}, 16'd0);
    rd(8'h54); rd(8'h55); chk("R5 bip event kept", {8'd0, s_rd}, 16'd5);
    step(4'd0, 5'b00001, 1, 0, 8'h56, 0);
    rd(8'h56); rd(8'h57); chk("R5 febe event kept", {8'd0, s_rd}, 16'd1);
  endtask

  task automatic t_status();
    rd(8'h15);
    step(4'd0, 5'b01000, 0, 0, 0, 0);
    rd(8'h15); chk("R6 trail bit 6", {8'd0, s_rd}, 16'h40);
    step(4'd1, 5'd0, 0, 0, 0, 0); step(0, 5'b00001, 0, 0, 0, 0);
    step(0, 5'b00010, 0, 0, 0, 0); step(0, 5'b00100, 0, 0, 0, 0);
    step(0, 5'b01000, 0, 0, 0, 0); step(0, 5'b10000, 0, 0, 0, 0);
    rd(8'h15); chk("R6 all live bits", {8'd0, s_rd}, 16'h5F);
    rd(8'h15); chk("R7 cleared by read", {8'd0, s_rd}, 16'h00);
    step(0, 5'b00010, 1, 0, 8'h15, 0);
    chk("R7 read during ferf event", {8'd0, s_rd}, 16'h00);
    rd(8'h15); chk("R7 ferf survives coincident read", {8'd0, s_rd}, 16'h08);
  endtask

  task automatic t_irq();
    rd(8'h15);
    step(0, 0, 0, 1, 8'h14, 8'hFF);
    rd(8'h14); chk("R8 enable readback masks 7,5", {8'd0, s_rd}, 16'h5F);
    step(0, 0, 0, 1, 8'h14, 8'h10);
    step(0, 5'b00010, 0, 0, 0, 0); idle();
    chk("R8 disabled ferf no irq", {15'd0, s_irq}, 16'd0);
    step(0, 5'b00001, 0, 0, 0, 0); idle();
    chk("R8 enabled febe raises irq", {15'd0, s_irq}, 16'd1);
    rd(8'h15); idle();
    chk("R8 irq drops after status read", {15'd0, s_irq}, 16'd0);
    step(0, 0, 0, 1, 8'h14, 8'h00);
  endtask

  task automatic t_febe_req();
    idle();
    step(4'd3, 5'd0, 0, 0, 0, 0);
    chk("R9 no req in event cycle", {15'd0, s_req}, 16'd0);
    idle(); chk("R9 req one cycle later", {15'd0, s_req}, 16'd1);
    idle(); chk("R9 req single cycle", {15'd0, s_req}, 16'd0);
    step(0, 5'b00001, 0, 0, 0, 0); idle();
    chk("R9 received flag alone no req", {15'd0, s_req}, 16'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bip_count();
    t_febe_count();
    t_hold();
    t_saturate();
    t_coincident();
    t_status();
    t_irq();
    t_febe_req();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule